// File: doc/BRIEF.md
# External Interrupt Request Controller

This block sits between a set of active-low external interrupt pins and the core's interrupt logic. Software programs a single read/write configuration word. Each pin owns a 4-bit slot in that word, holding a 2-bit priority code, a trigger-mode bit and a read-only status bit. The priority code both enables the source and selects one of three priority levels. The trigger-mode bit picks low-level or falling-edge sensing.

Every pin passes through a two-stage synchronizer. Sources in falling-edge mode capture their events in a per-source edge latch. That latch stays set until the core acknowledges the source. The block presents at most one request to the core: the highest priority level among the requesting sources, with ties resolved toward the lower-numbered source. The status bit of a slot reports the edge latch when the source is enabled in edge mode. Otherwise it reports the synchronized pin. A hardware reset or a software reset request returns every slot to disabled and level-sensitive.

Top module: `eirq_ctrl`

## Requirements
- R1: A hardware reset (`rst`) or a software reset request (`soft_rst`) clears every configuration field to zero. `soft_rst` takes precedence over a write in the same cycle. With the pins idle high, the word then reads 1 in each status position and 0 elsewhere.
- R2: In each 4-bit slot, bits 1:0 are the priority code: 00 disabled, 01 level 0, 10 level 1, 11 level 2. A granted request reports its source's level on `req_level`.
- R3: A write updates bits 2:0 of every slot. Bit 3 (status) is read-only, and a write has no effect on it.
- R4: Each pin passes through two synchronizing flops. A level-mode request appears two clock edges after the pin falls. An edge-mode request appears three edges after the pin falls.
- R5: An enabled level-mode source (slot bit 2 = 0) requests while its synchronized pin is low. It stops requesting once the synchronized pin is high again.
- R6: In edge mode (slot bit 2 = 1), a high-to-low transition of the synchronized pin sets the source's edge latch. The latch holds after the pin returns high. It clears only on an acknowledge (`ack` with `ack_src` equal to that source); an acknowledge naming another source leaves it set.
- R7: The status bit shows the edge latch (1 pending, 0 serviced) when the source is enabled in edge mode. Otherwise it shows the synchronized pin level.
- R8: A disabled source never requests, whatever its pin and trigger mode.
- R9: When several sources request at once, the highest level wins. Among equal levels, the lowest source index wins.
- R10: Enabling edge mode while the pin is already low sets no latch. Leaving edge mode, or disabling the source, clears the latch.
- R11: If a falling edge and an acknowledge of the same source meet in one cycle, the latch is left set.
- R12: When no request is presented, `req_valid`, `req_level` and `req_src` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset request, clears the configuration word |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 4*NUM_SRC | Write data, one 4-bit slot per source |
| rd_data | output | 4*NUM_SRC | Read data: configuration plus live status bits |
| irq_n | input | NUM_SRC | Active-low external interrupt pins |
| ack | input | 1 | Core acknowledges service of one source |
| ack_src | input | clog2(NUM_SRC) | Index of the acknowledged source |
| req_valid | output | 1 | A request is presented |
| req_level | output | 2 | Priority level of the presented request |
| req_src | output | clog2(NUM_SRC) | Index of the presented source |

## Verification
The bench measures synchronizer latency exactly. A design that is one stage short or long shifts the first request by a cycle and fails the two- or three-edge checks. It holds the pin low while edge mode is switched off and back on, which exposes a latch that survives a mode change or that counts an already-low pin as a new edge. It lines an acknowledge up with a fresh falling edge to catch a clear that beats the set. It also raises two equal-level requests together, so an arbiter that favours the higher index reports the wrong source.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    // Slot layout: [3] status (read-only), [2] trigger mode, [1:0] priority code
    localparam int SLOT_W = 4;
    localparam int CFG_W  = 3;

    typedef enum logic [1:0] {
        PRI_OFF = 2'b00,
        PRI_L0  = 2'b01,
        PRI_L1  = 2'b10,
        PRI_L2  = 2'b11
    } pri_code_e;

    typedef enum logic {
        TRIG_LOW  = 1'b0,
        TRIG_FALL = 1'b1
    } trig_e;

    typedef struct packed {
        trig_e     trig;
        pri_code_e pri;
    } src_cfg_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] level;
    } src_req_t;

    function automatic logic cfg_on(src_cfg_t c);
        return c.pri != PRI_OFF;
    endfunction

    function automatic logic cfg_edge(src_cfg_t c);
        return cfg_on(c) && (c.trig == TRIG_FALL);
    endfunction

    function automatic logic [1:0] cfg_level(src_cfg_t c);
        return 2'(c.pri - 2'd1);
    endfunction

endpackage

// File: rtl/eirq_cfg_reg.sv
module eirq_cfg_reg
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 3,
    localparam int REG_W  = NUM_SRC * SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       soft_rst,
    input  logic                       wr_en,
    input  logic [REG_W-1:0]           wr_data,
    output src_cfg_t [NUM_SRC-1:0]     cfg_o
);

    src_cfg_t [NUM_SRC-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_q[i] <= src_cfg_t'(wr_data[i*SLOT_W +: CFG_W]);
            end
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/eirq_src_chan.sv
module eirq_src_chan
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_n,
    input  src_cfg_t cfg,
    input  logic     ack_hit,
    output logic     status,
    output src_req_t req
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   sync_lvl;
    logic                   fall;
    logic                   edge_mode;

    assign sync_lvl  = chain_q[SYNC_STAGES-1];
    assign fall      = prev_q && !sync_lvl;
    assign edge_mode = cfg_edge(cfg);

    // pins idle high, so the chain resets to ones to avoid a false edge
    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= (chain_q << 1) | SYNC_STAGES'(pin_n);
            prev_q  <= sync_lvl;
        end
    end

    // a new edge outranks an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst || !edge_mode) begin
            latch_q <= 1'b0;
        end else if (fall) begin
            latch_q <= 1'b1;
        end else if (ack_hit) begin
            latch_q <= 1'b0;
        end
    end

    always_comb begin
        status    = edge_mode ? latch_q : sync_lvl;
        req.valid = cfg_on(cfg) && (edge_mode ? latch_q : !sync_lvl);
        req.level = cfg_level(cfg);
    end

endmodule

// File: rtl/eirq_prio_sel.sv
module eirq_prio_sel
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 3,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  src_req_t [NUM_SRC-1:0] reqs,
    output logic                   valid,
    output logic [1:0]             level,
    output logic [SRC_W-1:0]       src
);

    // strict comparison keeps the earlier (lower) index on ties
    always_comb begin
        valid = 1'b0;
        level = '0;
        src   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reqs[i].valid && (!valid || reqs[i].level > level)) begin
                valid = 1'b1;
                level = reqs[i].level;
                src   = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_SRC     = 3,
    parameter int SYNC_STAGES = 2,
    localparam int REG_W      = NUM_SRC * SLOT_W,
    localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] irq_n,
    input  logic             ack,
    input  logic [SRC_W-1:0] ack_src,
    output logic             req_valid,
    output logic [1:0]       req_level,
    output logic [SRC_W-1:0] req_src
);

    src_cfg_t [NUM_SRC-1:0] cfg;
    src_req_t [NUM_SRC-1:0] reqs;
    logic     [NUM_SRC-1:0] stat;

    eirq_cfg_reg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_o    (cfg)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        eirq_src_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .pin_n   (irq_n[g]),
            .cfg     (cfg[g]),
            .ack_hit (ack && (ack_src == SRC_W'(g))),
            .status  (stat[g]),
            .req     (reqs[g])
        );
        assign rd_data[g*SLOT_W +: SLOT_W] = {stat[g], cfg[g]};
    end

    eirq_prio_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .reqs  (reqs),
        .valid (req_valid),
        .level (req_level),
        .src   (req_src)
    );

endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk
    import eirq_pkg::*;
#(
    parameter int NUM_SRC = 3,
    localparam int REG_W  = NUM_SRC * SLOT_W,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             req_valid,
    input logic [1:0]       req_level,
    input logic [SRC_W-1:0] req_src
);

    function automatic logic [REG_W-1:0] cfg_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[i*SLOT_W +: CFG_W] = '1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] CMASK = cfg_bits();

    logic [1:0] win_pri;
    always_comb win_pri = 2'(rd_data >> (int'(req_src) * SLOT_W));

    // R1
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> ((rd_data & CMASK) == '0));

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !soft_rst) |=> ((rd_data & CMASK) == ($past(wr_data) & CMASK)));

    // R8
    no_disabled_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (win_pri != 2'b00));

    // R2
    level_from_field_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && win_pri != 2'b00) |-> (req_level == 2'(win_pri - 2'd1)));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (req_level == 2'd0 && req_src == '0));

endmodule

bind eirq_ctrl eirq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/eirq_ctrl_bench.sv
`timescale 1ns/100ps
module eirq_ctrl_bench;

    localparam int N  = 3;
    localparam int RW = 4 * N;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1, soft_rst = 1'b0, wr_en = 1'b0, ack = 1'b0;
    logic [RW-1:0] wr_data = '0;
    logic [RW-1:0] rd_data;
    logic [N-1:0]  irq_n = '1;
    logic [SW-1:0] ack_src = '0;
    logic          req_valid;
    logic [1:0]    req_level;
    logic [SW-1:0] req_src;

    always #2.5 clk = ~clk;

    eirq_ctrl #(.NUM_SRC(N)) u_eirq_ctrl (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .ack(ack),
        .ack_src(ack_src), .req_valid(req_valid), .req_level(req_level),
        .req_src(req_src)
    );

    typedef struct {
        logic [RW-1:0] rd;
        logic          v;
        logic [1:0]    lvl;
        logic [SW-1:0] src;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // slot = {status, trig, pri[1:0]}
    function automatic logic [RW-1:0] rdv(logic [2:0] c0, logic [2:0] c1,
                                          logic [2:0] c2, logic [2:0] st);
        return {st[2], c2, st[1], c1, st[0], c0};
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(logic [RW-1:0] rd, logic v, logic [1:0] lvl,
                              logic [SW-1:0] src, string tag);
        exp_t e;
        e.rd = rd; e.v = v; e.lvl = lvl; e.src = src; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // status positions written as 1 to show they are ignored (R3)
    task automatic wcfg(logic [2:0] c0, logic [2:0] c1, logic [2:0] c2);
        wr_data = rdv(c0, c1, c2, 3'b111);
        wr_en   = 1'b1;
        tick(1);
        wr_en   = 1'b0;
    endtask

    task automatic do_ack(logic [SW-1:0] s);
        ack = 1'b1; ack_src = s;
        tick(1);
        ack = 1'b0;
    endtask

    // monitor: compares queued expectations half a cycle after the edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (rd_data !== e.rd || req_valid !== e.v ||
                req_level !== e.lvl || req_src !== e.src) begin
                n_fail++;
                $display("FAIL %s: got rd=%h v=%b lvl=%0d src=%0d, expected rd=%h v=%b lvl=%0d src=%0d",
                         e.tag, rd_data, req_valid, req_level, req_src,
                         e.rd, e.v, e.lvl, e.src);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        expect_out(rdv(0,0,0,3'b111), 0, 0, 0, "R1 R12 reset state");

        wcfg(7,7,7);
        expect_out(rdv(7,7,7,3'b000), 0, 0, 0, "R3 R7 status ignores write");

        soft_rst = 1'b1; wr_en = 1'b1; wr_data = '1;
        tick(1);
        soft_rst = 1'b0; wr_en = 1'b0;
        expect_out(rdv(0,0,0,3'b111), 0, 0, 0, "R1 soft reset beats write");

        // level mode, source 0 at level 0
        wcfg(1,0,0);
        irq_n[0] = 1'b0;
        tick(1);
        expect_out(rdv(1,0,0,3'b111), 0, 0, 0, "R4 one stage not yet");
        tick(1);
        expect_out(rdv(1,0,0,3'b110), 1, 0, 0, "R4 R5 R7 level request");
        irq_n[0] = 1'b1;
        tick(2);
        expect_out(rdv(1,0,0,3'b111), 0, 0, 0, "R5 level released");

        // disabled source
        irq_n[1] = 1'b0;
        tick(2);
        expect_out(rdv(1,0,0,3'b101), 0, 0, 0, "R8 R7 disabled shows pin");
        irq_n[1] = 1'b1;
        tick(2);

        // edge mode, source 1 at level 1
        wcfg(1,6,0);
        expect_out(rdv(1,6,0,3'b101), 0, 0, 0, "R7 latch idle");
        irq_n[1] = 1'b0;
        tick(2);
        expect_out(rdv(1,6,0,3'b101), 0, 0, 0, "R4 edge not yet");
        tick(1);
        expect_out(rdv(1,6,0,3'b111), 1, 1, 1, "R4 R6 R2 edge request");
        irq_n[1] = 1'b1;
        tick(3);
        expect_out(rdv(1,6,0,3'b111), 1, 1, 1, "R6 latch holds");
        do_ack(0);
        expect_out(rdv(1,6,0,3'b111), 1, 1, 1, "R6 other ack ignored");
        do_ack(1);
        expect_out(rdv(1,6,0,3'b101), 0, 0, 0, "R6 ack clears");

        // arbitration
        wcfg(1,6,3);
        irq_n[0] = 1'b0; irq_n[2] = 1'b0;
        tick(2);
        expect_out(rdv(1,6,3,3'b000), 1, 2, 2, "R9 R2 highest level");
        wcfg(3,6,3);
        expect_out(rdv(3,6,3,3'b000), 1, 2, 0, "R9 tie lower index");
        irq_n[0] = 1'b1; irq_n[2] = 1'b1;
        tick(2);
        expect_out(rdv(3,6,3,3'b101), 0, 0, 0, "R5 all released");

        // enabling edge mode with pin already low
        wcfg(3,0,3);
        irq_n[1] = 1'b0;
        tick(3);
        expect_out(rdv(3,0,3,3'b101), 0, 0, 0, "R8 disabled low pin");
        wcfg(3,6,3);
        tick(3);
        expect_out(rdv(3,6,3,3'b101), 0, 0, 0, "R10 no edge when already low");
        irq_n[1] = 1'b1;
        tick(3);
        irq_n[1] = 1'b0;
        tick(3);
        expect_out(rdv(3,6,3,3'b111), 1, 1, 1, "R6 fresh edge");
        wcfg(3,0,3);
        expect_out(rdv(3,0,3,3'b101), 0, 0, 0, "R10 R8 disable drops request");
        wcfg(3,6,3);
        tick(3);
        expect_out(rdv(3,6,3,3'b101), 0, 0, 0, "R10 latch cleared by mode exit");

        // edge and acknowledge in the same cycle
        irq_n[1] = 1'b1;
        tick(3);
        irq_n[1] = 1'b0;
        tick(3);
        irq_n[1] = 1'b1;
        tick(3);
        irq_n[1] = 1'b0;
        tick(2);
        do_ack(1);
        expect_out(rdv(3,6,3,3'b111), 1, 1, 1, "R11 set beats ack");
        do_ack(1);
        expect_out(rdv(3,6,3,3'b101), 0, 0, 0, "R6 later ack clears");

        tick(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule